// File: doc/BRIEF.md
# Load/Store Address Fault Capture

This block sits between the register read stage and the memory access stage of a 64-bit processor pipeline. For every load or store it forms the effective virtual address by adding a sign-extended 16-bit immediate to a 64-bit base operand. It also checks that address against the natural alignment of the access size. The address leaves the block combinationally, so an external translation stage can look it up in the same cycle and return a fault indication with its own exception code.

When an accepted access is misaligned, or is aligned but rejected by translation, the block latches the offending virtual address into a 64-bit faulting-address register. It raises a one-cycle exception strobe with a 5-bit cause code and sets a sticky exception flag. No memory request is issued for that access. An access that passes both checks produces a one-cycle memory request instead.

A separate combinational read port serves move-from-coprocessor-0 instructions. It is selected by a 5-bit register number and a 3-bit select field, and it returns the faulting-address register or one of three 32-bit control registers that are supplied from outside.

Top module: `addr_fault_capture`

## Requirements
- R1: `vaddr` equals `base` plus `offset` sign-extended to 64 bits, modulo 2^64, in the same cycle the operands are presented.
- R2: `op_size` encodes the access width as log2 of the byte count (0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes). A load (`op_is_store` = 0) whose `vaddr` has any of its low `op_size` bits set is misaligned. On the clock edge that accepts it (`op_valid` = 1), `exc_valid` goes to 1 with `exc_code` = 4 for the following cycle.
- R3: A misaligned store (`op_is_store` = 1) gives `exc_valid` = 1 with `exc_code` = 5 in the cycle after it is accepted.
- R4: After an accepted misaligned access, `badvaddr` holds that access's `vaddr`.
- R5: An accepted aligned access with `xlat_fault` = 1 gives `exc_valid` = 1 and `exc_code` = `xlat_code` in the next cycle, and `badvaddr` then holds its `vaddr`.
- R6: Misalignment takes priority over a translation fault. A misaligned access reports code 4 or 5 whatever the values of `xlat_fault` and `xlat_code`.
- R7: `exc_flag` becomes 1 in the cycle after any reported fault and stays 1 until reset.
- R8: An accepted aligned access without a translation fault gives `mem_req` = 1 for exactly the next cycle. `mem_req` and `exc_valid` are never 1 together.
- R9: In a cycle with `op_valid` = 0, the next cycle has `exc_valid` = 0 and `mem_req` = 0, and `badvaddr` is unchanged.
- R10: With `rd_reg` = 8 and `rd_sel` = 0, `rd_data` equals the full 64-bit `badvaddr`.
- R11: With `rd_sel` = 0, `rd_reg` values 11, 12 and 13 return `compare_in`, `status_in` and `cause_in` respectively, zero-extended to 64 bits.
- R12: Any other `rd_reg`/`rd_sel` pair returns zero, and no read changes `badvaddr` or `exc_flag`.
- R13: A synchronous active-high `rst` clears `badvaddr`, `exc_flag`, `exc_valid` and `mem_req` in the cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A load or store is presented this cycle |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | log2 of access width in bytes |
| base | input | 64 | Base register operand |
| offset | input | 16 | Signed immediate offset |
| xlat_fault | input | 1 | Translation stage rejects `vaddr` |
| xlat_code | input | 5 | Exception code supplied by translation |
| rd_reg | input | 5 | Coprocessor-0 register number to read |
| rd_sel | input | 3 | Coprocessor-0 select field |
| compare_in | input | 32 | Timer compare register value |
| status_in | input | 32 | Status register value |
| cause_in | input | 32 | Cause register value |
| vaddr | output | 64 | Effective virtual address (combinational) |
| mem_req | output | 1 | One-cycle memory access request |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_code | output | 5 | Exception cause code |
| exc_flag | output | 1 | Sticky exception-signalled flag |
| badvaddr | output | 64 | Faulting virtual address register |
| rd_data | output | 64 | Coprocessor-0 read data (combinational) |

## Verification
`vaddr` and `rd_data` depend on the inputs alone. They are due in the cycle the inputs are presented, so the bench samples them shortly after driving inputs on a falling edge. `mem_req`, `exc_valid`, `exc_code`, `badvaddr` and `exc_flag` each pass through one register. The bench samples them on the next falling edge, half a period after the rising edge that accepted the access, and compares them with a model updated for that edge. Read-port checks come after the capture has settled and before the next access, so that a read is seen not to disturb `badvaddr`.

// File: rtl/addr_fault_pkg.sv
package addr_fault_pkg;

    localparam int XLEN  = 64;
    localparam int OFFW  = 16;
    localparam int ECW   = 5;
    localparam int CRW   = 32;
    localparam int REGW  = 5;
    localparam int SELW  = 3;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } acc_size_e;

    localparam logic [ECW-1:0] EXC_ADDR_LOAD  = 5'd4;
    localparam logic [ECW-1:0] EXC_ADDR_STORE = 5'd5;

    localparam logic [REGW-1:0] C0_FAULT_ADDR = 5'd8;
    localparam logic [REGW-1:0] C0_COMPARE    = 5'd11;
    localparam logic [REGW-1:0] C0_STATUS     = 5'd12;
    localparam logic [REGW-1:0] C0_CAUSE      = 5'd13;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_ACCESS = 2'd1,
        OUT_FAULT  = 2'd2
    } outcome_e;

    typedef struct packed {
        logic            valid;
        logic            is_store;
        logic            misaligned;
        logic [XLEN-1:0] vaddr;
    } acc_req_t;

    typedef struct packed {
        outcome_e       kind;
        logic [ECW-1:0] code;
    } decision_t;

    function automatic logic low_bits_set(logic [2:0] addr_lsb, acc_size_e sz);
        logic [2:0] mask;
        mask = 3'((4'd1 << sz) - 4'd1);
        return |(addr_lsb & mask);
    endfunction

    function automatic decision_t decide(acc_req_t req, logic xf, logic [ECW-1:0] xc);
        decision_t d;
        d.kind = OUT_IDLE;
        d.code = '0;
        if (req.valid) begin
            if (req.misaligned) begin
                d.kind = OUT_FAULT;
                d.code = req.is_store ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
            end else if (xf) begin
                d.kind = OUT_FAULT;
                d.code = xc;
            end else begin
                d.kind = OUT_ACCESS;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/afc_addr_gen.sv
module afc_addr_gen
    import addr_fault_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int OW = OFFW
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] offset,
    input  acc_size_e     size,
    output logic [AW-1:0] vaddr,
    output logic          misaligned
);
    localparam int EXTW = AW - OW;

    logic [AW-1:0] offset_sx;

    always_comb begin
        offset_sx  = {{EXTW{offset[OW-1]}}, offset};
        vaddr      = base + offset_sx;
        misaligned = low_bits_set(vaddr[2:0], size);
    end
endmodule

// File: rtl/afc_fault_capture.sv
module afc_fault_capture
    import addr_fault_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int CW = ECW
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_req_t      req,
    input  logic          xlat_fault,
    input  logic [CW-1:0] xlat_code,
    output logic          mem_req,
    output logic          exc_valid,
    output logic [CW-1:0] exc_code,
    output logic          exc_flag,
    output logic [AW-1:0] badvaddr
);
    decision_t dec;

    always_comb begin
        dec = decide(req, xlat_fault, xlat_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            exc_valid <= 1'b0;
            exc_code  <= '0;
            exc_flag  <= 1'b0;
            badvaddr  <= '0;
        end else begin
            mem_req   <= (dec.kind == OUT_ACCESS);
            exc_valid <= (dec.kind == OUT_FAULT);
            if (dec.kind == OUT_FAULT) begin
                exc_code <= dec.code;
                exc_flag <= 1'b1;
                badvaddr <= req.vaddr;
            end
        end
    end
endmodule

// File: rtl/afc_cop0_read.sv
module afc_cop0_read
    import addr_fault_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int RW = CRW
) (
    input  logic [REGW-1:0] rd_reg,
    input  logic [SELW-1:0] rd_sel,
    input  logic [AW-1:0]   fault_addr,
    input  logic [RW-1:0]   compare_in,
    input  logic [RW-1:0]   status_in,
    input  logic [RW-1:0]   cause_in,
    output logic [AW-1:0]   rd_data
);
    localparam int NCTL = 3;
    localparam int PADW = AW - RW;

    logic [REGW-1:0] ctl_idx [NCTL];
    logic [RW-1:0]   ctl_val [NCTL];
    logic [NCTL-1:0] ctl_hit;

    assign ctl_idx[0] = C0_COMPARE;
    assign ctl_idx[1] = C0_STATUS;
    assign ctl_idx[2] = C0_CAUSE;
    assign ctl_val[0] = compare_in;
    assign ctl_val[1] = status_in;
    assign ctl_val[2] = cause_in;

    for (genvar i = 0; i < NCTL; i++) begin : g_hit
        assign ctl_hit[i] = (rd_sel == '0) && (rd_reg == ctl_idx[i]);
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == '0 && rd_reg == C0_FAULT_ADDR) begin
            rd_data = fault_addr;
        end
        for (int i = 0; i < NCTL; i++) begin
            if (ctl_hit[i]) begin
                rd_data = {{PADW{1'b0}}, ctl_val[i]};
            end
        end
    end
endmodule

// File: rtl/addr_fault_capture.sv
module addr_fault_capture
    import addr_fault_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic        op_is_store,
    input  logic [1:0]  op_size,
    input  logic [63:0] base,
    input  logic [15:0] offset,
    input  logic        xlat_fault,
    input  logic [4:0]  xlat_code,
    input  logic [4:0]  rd_reg,
    input  logic [2:0]  rd_sel,
    input  logic [31:0] compare_in,
    input  logic [31:0] status_in,
    input  logic [31:0] cause_in,
    output logic [63:0] vaddr,
    output logic        mem_req,
    output logic        exc_valid,
    output logic [4:0]  exc_code,
    output logic        exc_flag,
    output logic [63:0] badvaddr,
    output logic [63:0] rd_data
);
    acc_req_t  req;
    logic      misal;
    acc_size_e size_e;

    assign size_e = acc_size_e'(op_size);

    afc_addr_gen #(.AW(XLEN), .OW(OFFW)) u_agen (
        .base       (base),
        .offset     (offset),
        .size       (size_e),
        .vaddr      (vaddr),
        .misaligned (misal)
    );

    always_comb begin
        req.valid      = op_valid;
        req.is_store   = op_is_store;
        req.misaligned = misal;
        req.vaddr      = vaddr;
    end

    afc_fault_capture #(.AW(XLEN), .CW(ECW)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .xlat_fault (xlat_fault),
        .xlat_code  (xlat_code),
        .mem_req    (mem_req),
        .exc_valid  (exc_valid),
        .exc_code   (exc_code),
        .exc_flag   (exc_flag),
        .badvaddr   (badvaddr)
    );

    afc_cop0_read #(.AW(XLEN), .RW(CRW)) u_rd (
        .rd_reg     (rd_reg),
        .rd_sel     (rd_sel),
        .fault_addr (badvaddr),
        .compare_in (compare_in),
        .status_in  (status_in),
        .cause_in   (cause_in),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/addr_fault_capture_chk.sv
module addr_fault_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic        op_is_store,
    input logic [1:0]  op_size,
    input logic [63:0] vaddr,
    input logic        mem_req,
    input logic        exc_valid,
    input logic [4:0]  exc_code,
    input logic        exc_flag,
    input logic [63:0] badvaddr,
    input logic [4:0]  rd_reg,
    input logic [2:0]  rd_sel,
    input logic [63:0] rd_data
);
    logic bad_align;
    always_comb begin
        case (op_size)
            2'd0:    bad_align = 1'b0;
            2'd1:    bad_align = vaddr[0];
            2'd2:    bad_align = |vaddr[1:0];
            default: bad_align = |vaddr[2:0];
        endcase
    end

    p_load_code_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_is_store && bad_align) |=> (exc_valid && exc_code == 5'd4));

    p_store_code_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_is_store && bad_align) |=> (exc_valid && exc_code == 5'd5));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && bad_align) |=> (badvaddr == $past(vaddr)));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        exc_flag |=> exc_flag);

    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> exc_flag);

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && exc_valid));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!exc_valid && !mem_req && $stable(badvaddr)));

    p_read_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_reg == 5'd8 && rd_sel == 3'd0) |-> (rd_data == badvaddr));
endmodule

bind addr_fault_capture addr_fault_capture_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_is_store (op_is_store),
    .op_size     (op_size),
    .vaddr       (vaddr),
    .mem_req     (mem_req),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code),
    .exc_flag    (exc_flag),
    .badvaddr    (badvaddr),
    .rd_reg      (rd_reg),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data)
);

// File: tb/addr_fault_capture_test.sv
module addr_fault_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, op_is_store = 1'b0;
    logic [1:0]  op_size = '0;
    logic [63:0] base = '0;
    logic [15:0] offset = '0;
    logic        xlat_fault = 1'b0;
    logic [4:0]  xlat_code = '0;
    logic [4:0]  rd_reg = '0;
    logic [2:0]  rd_sel = 3'd1;
    logic [31:0] compare_in = 32'hC0DE_0011;
    logic [31:0] status_in  = 32'h8000_F00D;
    logic [31:0] cause_in   = 32'hFFFF_FFFF;
    logic [63:0] vaddr, badvaddr, rd_data;
    logic        mem_req, exc_valid, exc_flag;
    logic [4:0]  exc_code;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_bad = '0;
    logic        m_flag = 1'b0;

    always #4 clk = ~clk;

    addr_fault_capture uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_is_store(op_is_store),
        .op_size(op_size), .base(base), .offset(offset), .xlat_fault(xlat_fault),
        .xlat_code(xlat_code), .rd_reg(rd_reg), .rd_sel(rd_sel),
        .compare_in(compare_in), .status_in(status_in), .cause_in(cause_in),
        .vaddr(vaddr), .mem_req(mem_req), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_flag(exc_flag), .badvaddr(badvaddr), .rd_data(rd_data)
    );

    function automatic logic [63:0] ref_addr(logic [63:0] b, logic [15:0] o);
        return b + {{48{o[15]}}, o};
    endfunction

    function automatic logic ref_misal(logic [63:0] a, logic [1:0] s);
        logic [63:0] m;
        m = (64'd1 << s) - 64'd1;
        return (a & m) != 0;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic v, input logic st, input logic [1:0] sz,
                         input logic [63:0] b, input logic [15:0] o,
                         input logic xf, input logic [4:0] xc);
        logic [63:0] ea;
        logic        mis, e_exc, e_mem;
        logic [4:0]  e_code;
        op_valid = v; op_is_store = st; op_size = sz; base = b; offset = o;
        xlat_fault = xf; xlat_code = xc;
        ea = ref_addr(b, o);
        mis = ref_misal(ea, sz);
        #1;
        chk(vaddr == ea, "R1 vaddr", vaddr, ea);
        e_exc = 1'b0; e_mem = 1'b0; e_code = '0;
        if (v && mis) begin
            e_exc = 1'b1; e_code = st ? 5'd5 : 5'd4; m_bad = ea; m_flag = 1'b1;
        end else if (v && xf) begin
            e_exc = 1'b1; e_code = xc; m_bad = ea; m_flag = 1'b1;
        end else if (v) begin
            e_mem = 1'b1;
        end
        @(negedge clk);
        op_valid = 1'b0;
        chk(exc_valid == e_exc, v ? (mis ? "R6 exc_valid" : "R5 exc_valid") : "R9 exc_valid",
            64'(exc_valid), 64'(e_exc));
        if (e_exc)
            chk(exc_code == e_code, mis ? (st ? "R3 code" : "R2 code") : "R5 code",
                64'(exc_code), 64'(e_code));
        chk(mem_req == e_mem, "R8 mem_req", 64'(mem_req), 64'(e_mem));
        chk(badvaddr == m_bad, mis ? "R4 badvaddr" : "R9 badvaddr", badvaddr, m_bad);
        chk(exc_flag == m_flag, "R7 exc_flag", 64'(exc_flag), 64'(m_flag));
    endtask

    task automatic rd_chk(input logic [4:0] r, input logic [2:0] s,
                          input logic [63:0] exp, input string req);
        rd_reg = r; rd_sel = s;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        logic [63:0] rb;
        seed = 32'd7321;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(badvaddr == 0, "R13 badvaddr reset", badvaddr, 0);
        chk(exc_flag == 0, "R13 flag reset", 64'(exc_flag), 0);
        chk(exc_valid == 0 && mem_req == 0, "R13 strobes reset",
            64'({exc_valid, mem_req}), 0);

        // directed corner cases
        do_op(1, 0, 2'd3, 64'h1000, 16'h0008, 0, 0);            // aligned double
        do_op(1, 0, 2'd1, 64'h0, 16'hFFFF, 0, 0);                // wrap to all-ones, misaligned half load (R2)
        do_op(1, 1, 2'd2, 64'h7FFF_FFFF_FFFF_FFFE, 16'h0004, 0, 0); // misaligned word store (R3)
        do_op(1, 0, 2'd0, 64'h1234_5678_9ABC_DEF1, 16'h8000, 0, 0); // byte is always aligned
        do_op(1, 1, 2'd3, 64'hABCD_0000_0000_0010, 16'h0000, 1, 5'd3); // translation fault (R5)
        do_op(1, 0, 2'd2, 64'h20, 16'h0002, 1, 5'd2);            // misaligned + xlat: R6
        do_op(0, 1, 2'd3, 64'h3, 16'h0001, 1, 5'd7);             // idle: R9

        // read port
        rd_chk(5'd8,  3'd0, m_bad, "R10 fault addr read");
        rd_chk(5'd11, 3'd0, {32'h0, compare_in}, "R11 compare");
        rd_chk(5'd12, 3'd0, {32'h0, status_in},  "R11 status");
        rd_chk(5'd13, 3'd0, {32'h0, cause_in},   "R11 cause");
        rd_chk(5'd8,  3'd1, 64'h0, "R12 reg8 sel1");
        rd_chk(5'd9,  3'd0, 64'h0, "R12 reg9");
        rd_chk(5'd13, 3'd7, 64'h0, "R12 reg13 sel7");
        @(negedge clk);
        chk(badvaddr == m_bad, "R12 read leaves badvaddr", badvaddr, m_bad);
        chk(exc_flag == m_flag, "R12 read leaves flag", 64'(exc_flag), 64'(m_flag));

        // random mix
        for (int i = 0; i < 400; i++) begin
            rb = {$urandom, $urandom};
            do_op(($urandom % 5) != 0, 1'($urandom), 2'($urandom),
                  rb, 16'($urandom), ($urandom % 4) == 0, 5'($urandom));
            if (i % 16 == 0) rd_chk(5'd8, 3'd0, m_bad, "R10 fault addr read");
            if (i % 16 == 1) rd_chk(5'd12, 3'd0, {32'h0, status_in}, "R11 status");
        end

        // mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_bad = '0; m_flag = 1'b0;
        chk(badvaddr == 0, "R13 badvaddr reset", badvaddr, 0);
        chk(exc_flag == 0, "R13 flag reset", 64'(exc_flag), 0);
        rd_chk(5'd8, 3'd0, 64'h0, "R10 read after reset");
        do_op(1, 1, 2'd1, 64'h5, 16'h0000, 0, 0);
        rd_chk(5'd8, 3'd0, 64'h5, "R10 read after capture");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule